// File: doc/BRIEF.md
# Programmable Priority Interrupt Resolver

This block looks at a software-programmed table of priority slots and reports, in one 32-bit status word, which interrupt source currently has the highest priority on the fast-interrupt (FIQ) path and which has it on the normal-interrupt (IRQ) path. Each slot names one source and carries its own enable bit. The position of a slot in the table sets its priority. The source number does not. The same source may appear in more than one slot, and a slot may name a source that does not exist.

A source counts as active when it is both pending and unmasked. Its steering bit sends it to one of the two paths. The block scans all slots at once and picks the lowest-indexed qualifying slot for each path independently. It then packs both results into the status word, which is registered and refreshed on every clock. The table storage and the register bus that writes it sit outside the block and arrive as plain input vectors.

Top module: `irq_prio_resolver`

## Requirements
- R1: While `rst_n` is low the status word holds 0x003F003F.
- R2: A slot takes part only when its bit 31 is set and its ID field (bits 5:0) is below `NUM_SRC`; slot bits 30:6 have no effect on the result.
- R3: A source is active only when its bit is set in both `pend_vec` and `mask_vec`; a pending but masked source is never reported.
- R4: An active source whose `steer_vec` bit is 1 competes on the FIQ path only; one whose bit is 0 competes on the IRQ path only.
- R5: When several qualifying slots feed the same path, the slot with the smallest index wins, and the reported value is the source ID held in that slot.
- R6: Status layout: bit 31 = IRQ winner valid, bits 21:16 = IRQ source ID, bit 15 = FIQ winner valid, bits 5:0 = FIQ source ID.
- R7: A path with no qualifying slot reports ID 0x3F with its valid bit clear.
- R8: The two paths are resolved independently; adding or removing a winner on one path leaves the other path's field unchanged.
- R9: Status bits 30:22 and 14:6 are always zero.
- R10: The status word reflects the inputs sampled at the previous rising clock edge (one cycle of latency).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_tbl | input | NUM_SLOTS*32 | Priority table; slot i occupies bits i*32+31 down to i*32 |
| pend_vec | input | NUM_SRC | Pending state per source |
| mask_vec | input | NUM_SRC | Unmask per source (1 = enabled) |
| steer_vec | input | NUM_SRC | Path select per source (1 = FIQ, 0 = IRQ) |
| status_word | output | 32 | Registered winner report for both paths |

## Verification
The bench uses the default 40 slots and 40 sources. With these values the 6-bit ID field can hold the out-of-range values 40 to 63, so random tables mix rejected IDs, disabled slots, junk in the unused slot bits and sources named twice. A scan model that walks the table in order is compared with the status word on every clock. Directed cases pin down layout, masking, steering, slot ordering, the independence of the two paths and the single cycle of latency.

// File: rtl/prs_pkg.sv
package prs_pkg;
  localparam int WORD_W       = 32;
  localparam int ID_W         = 6;
  localparam int SLOT_EN_BIT  = 31;
  localparam int IRQ_FLAG_BIT = 31;
  localparam int IRQ_ID_LSB   = 16;
  localparam int FIQ_FLAG_BIT = 15;
  localparam int FIQ_ID_LSB   = 0;
  localparam logic [ID_W-1:0] NO_ID = '1;

  typedef struct packed {
    logic            found;
    logic [ID_W-1:0] id;
  } winner_t;

  // Slot qualifies when enabled and naming an existing source.
  function automatic logic slot_usable(input logic [WORD_W-1:0] w,
                                       input int unsigned nsrc);
    return w[SLOT_EN_BIT] && (32'(w[ID_W-1:0]) < nsrc);
  endfunction

  // Build the status word from the two path winners.
  function automatic logic [WORD_W-1:0] pack_status(input winner_t irq_w,
                                                    input winner_t fiq_w);
    logic [WORD_W-1:0] word;
    word = '0;
    word[IRQ_FLAG_BIT]            = irq_w.found;
    word[IRQ_ID_LSB +: ID_W]      = irq_w.found ? irq_w.id : NO_ID;
    word[FIQ_FLAG_BIT]            = fiq_w.found;
    word[FIQ_ID_LSB +: ID_W]      = fiq_w.found ? fiq_w.id : NO_ID;
    return word;
  endfunction
endpackage

// File: rtl/prs_slot_class.sv
module prs_slot_class
  import prs_pkg::*;
#(
  parameter int NUM_SLOTS = 40,
  parameter int NUM_SRC   = 40
) (
  input  logic [NUM_SLOTS*WORD_W-1:0] slot_tbl,
  input  logic [NUM_SRC-1:0]          act_vec,
  input  logic [NUM_SRC-1:0]          steer_vec,
  output logic [NUM_SLOTS-1:0]        fiq_hit,
  output logic [NUM_SLOTS-1:0]        irq_hit,
  output logic [NUM_SLOTS*ID_W-1:0]   slot_ids
);
  localparam int SRC_IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [WORD_W-1:0]    word;
    logic [ID_W-1:0]      raw_id;
    logic                 usable;
    logic [SRC_IDX_W-1:0] src_idx;
    logic                 src_live;

    assign word     = slot_tbl[s*WORD_W +: WORD_W];
    assign raw_id   = word[ID_W-1:0];
    assign usable   = slot_usable(word, NUM_SRC);
    assign src_idx  = usable ? SRC_IDX_W'(raw_id) : '0;
    assign src_live = usable && act_vec[src_idx];

    assign fiq_hit[s] = src_live &&  steer_vec[src_idx];
    assign irq_hit[s] = src_live && !steer_vec[src_idx];
    assign slot_ids[s*ID_W +: ID_W] = raw_id;
  end
endmodule

// File: rtl/prs_first_pick.sv
module prs_first_pick
  import prs_pkg::*;
#(
  parameter int NUM_SLOTS = 40
) (
  input  logic [NUM_SLOTS-1:0]      hit,
  input  logic [NUM_SLOTS*ID_W-1:0] slot_ids,
  output winner_t                   win
);
  // Walk from the top so the lowest set index is the last assignment.
  always_comb begin
    win.found = 1'b0;
    win.id    = NO_ID;
    for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
      if (hit[s]) begin
        win.found = 1'b1;
        win.id    = slot_ids[s*ID_W +: ID_W];
      end
    end
  end
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
  import prs_pkg::*;
#(
  parameter int NUM_SLOTS = 40,
  parameter int NUM_SRC   = 40
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_SLOTS*WORD_W-1:0] slot_tbl,
  input  logic [NUM_SRC-1:0]          pend_vec,
  input  logic [NUM_SRC-1:0]          mask_vec,
  input  logic [NUM_SRC-1:0]          steer_vec,
  output logic [WORD_W-1:0]           status_word
);
  localparam logic [WORD_W-1:0] IDLE_WORD =
    {1'b0, 9'b0, NO_ID, 1'b0, 9'b0, NO_ID};

  logic [NUM_SRC-1:0]        act_vec;
  logic [NUM_SLOTS-1:0]      fiq_hit;
  logic [NUM_SLOTS-1:0]      irq_hit;
  logic [NUM_SLOTS*ID_W-1:0] slot_ids;
  winner_t                   fiq_win;
  winner_t                   irq_win;
  logic [WORD_W-1:0]         next_word;

  assign act_vec = pend_vec & mask_vec;

  prs_slot_class #(.NUM_SLOTS(NUM_SLOTS), .NUM_SRC(NUM_SRC)) u_class (
    .slot_tbl (slot_tbl),
    .act_vec  (act_vec),
    .steer_vec(steer_vec),
    .fiq_hit  (fiq_hit),
    .irq_hit  (irq_hit),
    .slot_ids (slot_ids)
  );

  prs_first_pick #(.NUM_SLOTS(NUM_SLOTS)) u_pick_fiq (
    .hit     (fiq_hit),
    .slot_ids(slot_ids),
    .win     (fiq_win)
  );

  prs_first_pick #(.NUM_SLOTS(NUM_SLOTS)) u_pick_irq (
    .hit     (irq_hit),
    .slot_ids(slot_ids),
    .win     (irq_win)
  );

  assign next_word = pack_status(irq_win, fiq_win);

  always_ff @(posedge clk) begin
    if (!rst_n) status_word <= IDLE_WORD;
    else        status_word <= next_word;
  end

  // R1: reset value
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> status_word == IDLE_WORD);

  // R9: padding bits stay zero
  a_r9_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[30:22] == '0 && status_word[14:6] == '0);

  // R10 / R6: winners land in their fields one cycle later
  a_r10_fiq_latched: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_win.found |=> status_word[FIQ_FLAG_BIT] &&
                      status_word[FIQ_ID_LSB +: ID_W] == $past(fiq_win.id));
  a_r10_irq_latched: assert property (@(posedge clk) disable iff (!rst_n)
    irq_win.found |=> status_word[IRQ_FLAG_BIT] &&
                      status_word[IRQ_ID_LSB +: ID_W] == $past(irq_win.id));

  // R7: empty path reads as the no-winner code
  a_r7_fiq_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !fiq_win.found |=> !status_word[FIQ_FLAG_BIT] &&
                       status_word[FIQ_ID_LSB +: ID_W] == NO_ID);
  a_r7_irq_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_win.found |=> !status_word[IRQ_FLAG_BIT] &&
                       status_word[IRQ_ID_LSB +: ID_W] == NO_ID);

  // R2: a reported source always exists
  a_r2_fiq_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_win.found |-> 32'(fiq_win.id) < NUM_SRC);
  a_r2_irq_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    irq_win.found |-> 32'(irq_win.id) < NUM_SRC);

  // R3 / R4: a winner is active and steered to its own path
  a_r4_fiq_steer: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_win.found |-> act_vec[fiq_win.id] && steer_vec[fiq_win.id]);
  a_r4_irq_steer: assert property (@(posedge clk) disable iff (!rst_n)
    irq_win.found |-> act_vec[irq_win.id] && !steer_vec[irq_win.id]);
endmodule

// File: tb/irq_prio_resolver_bench.sv
module irq_prio_resolver_bench;
  localparam int NS = 40;
  localparam int NSRC = 40;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NS*32-1:0]  slot_tbl = '0;
  logic [NSRC-1:0]   pend_vec = '0;
  logic [NSRC-1:0]   mask_vec = '0;
  logic [NSRC-1:0]   steer_vec = '0;
  logic [31:0]       status_word;

  logic [31:0] tbl [NS];
  logic [NSRC-1:0] pend_m, mask_m, steer_m;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  logic [31:0] prev_exp;

  always #4 clk = ~clk;

  irq_prio_resolver #(.NUM_SLOTS(NS), .NUM_SRC(NSRC)) u_irq_prio_resolver (
    .clk(clk), .rst_n(rst_n), .slot_tbl(slot_tbl), .pend_vec(pend_vec),
    .mask_vec(mask_vec), .steer_vec(steer_vec), .status_word(status_word));

  // Scan model: walk slots in order, keep the first hit per path.
  function automatic logic [31:0] model();
    int irq_id = -1;
    int fiq_id = -1;
    logic [31:0] w;
    for (int s = 0; s < NS; s++) begin
      int id;
      id = int'(tbl[s][5:0]);
      if (!tbl[s][31] || id >= NSRC) continue;
      if (!(pend_m[id] && mask_m[id])) continue;
      if (steer_m[id]) begin
        if (fiq_id < 0) fiq_id = id;
      end else if (irq_id < 0) irq_id = id;
    end
    w = 32'h0;
    w[31]    = (irq_id >= 0);
    w[21:16] = (irq_id >= 0) ? 6'(irq_id) : 6'h3F;
    w[15]    = (fiq_id >= 0);
    w[5:0]   = (fiq_id >= 0) ? 6'(fiq_id) : 6'h3F;
    return w;
  endfunction

  task automatic check(input string req, input logic [31:0] exp);
    n_cmp++;
    if (status_word !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", req, status_word, exp);
    end
  endtask

  task automatic clear_model();
    for (int s = 0; s < NS; s++) tbl[s] = '0;
    pend_m = '0; mask_m = '0; steer_m = '0;
  endtask

  // Drive at the falling edge, sample 1 ns after the next rising edge.
  task automatic step(input string req);
    logic [31:0] exp;
    @(negedge clk);
    for (int s = 0; s < NS; s++) slot_tbl[s*32 +: 32] = tbl[s];
    pend_vec = pend_m; mask_vec = mask_m; steer_vec = steer_m;
    exp = model();
    @(posedge clk); #1;
    check(req, exp);
    prev_exp = exp;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    clear_model();
    // R1: busy inputs during reset must not leak out
    tbl[0] = 32'h8000_0003; pend_m[3] = 1; mask_m[3] = 1;
    @(negedge clk);
    for (int s = 0; s < NS; s++) slot_tbl[s*32 +: 32] = tbl[s];
    pend_vec = pend_m; mask_vec = mask_m;
    repeat (3) @(posedge clk);
    #1 check("R1 reset", 32'h003F_003F);
    @(negedge clk); rst_n = 1'b1;

    clear_model();
    step("R7 empty");
    check("R7 empty word", 32'h003F_003F);

    // R6 / R4: IRQ path
    tbl[5] = 32'h8000_000A; pend_m[10] = 1; mask_m[10] = 1;
    step("R6 irq layout");
    check("R4 irq only", 32'h800A_003F);
    steer_m[10] = 1;
    step("R4 fiq steer");
    check("R6 fiq layout", 32'h003F_800A);

    // R2: disabled slot, out-of-range ID, junk bits
    tbl[5] = 32'h0000_000A;
    step("R2 slot disabled");
    check("R2 disabled word", 32'h003F_003F);
    tbl[5] = 32'h8000_002D;
    step("R2 id 45 rejected");
    tbl[5] = 32'hFFFF_FFCA;
    step("R2 junk bits ignored");
    check("R2 junk word", 32'h003F_800A);

    // R3: masked source
    mask_m[10] = 0;
    step("R3 masked");
    check("R3 masked word", 32'h003F_003F);

    // R5: lowest slot wins, reported value is the source ID
    clear_model();
    tbl[3] = 32'h8000_0007; tbl[1] = 32'h8000_0014; tbl[0] = 32'h8000_0027;
    pend_m[7] = 1; mask_m[7] = 1; pend_m[20] = 1; mask_m[20] = 1;
    step("R5 order");
    check("R5 slot1 wins", 32'h8014_003F);
    pend_m[20] = 0;
    step("R5 next slot");
    check("R5 slot3 wins", 32'h8007_003F);
    // same source in two slots
    tbl[0] = 32'h8000_0007;
    step("R5 duplicate");

    // R8: independent paths
    tbl[2] = 32'h8000_0021; pend_m[33] = 1; mask_m[33] = 1; steer_m[33] = 1;
    step("R8 both");
    check("R8 both word", 32'h8007_8021);
    pend_m[7] = 0;
    step("R8 irq removed");
    check("R8 fiq kept", 32'h003F_8021);

    // R10: one cycle of latency
    pend_m[7] = 1;
    @(negedge clk);
    pend_vec = pend_m;
    #1 check("R10 before edge", prev_exp);
    @(posedge clk); #1;
    check("R10 after edge", 32'h8007_8021);

    // R5 R8 R9 random tables with duplicates and bad IDs
    for (int n = 0; n < 3000; n++) begin
      for (int s = 0; s < NS; s++) begin
        tbl[s] = $urandom;
        tbl[s][31] = ($urandom_range(0, 3) != 0);
        tbl[s][5:0] = ($urandom_range(0, 4) == 0) ? 6'($urandom_range(40, 63))
                                                  : 6'($urandom_range(0, 39));
      end
      pend_m  = {$urandom, $urandom} & {$urandom, $urandom};
      mask_m  = {$urandom, $urandom};
      steer_m = {$urandom, $urandom};
      if (n % 7 == 0) pend_m = '0;
      step("R5 R8 R9 random");
      if (status_word[30:22] != 0 || status_word[14:6] != 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R9: got %08h expected zero padding", status_word);
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule